// File: doc/BRIEF.md
# DCC Track Waveform Generator with Fault Injection

The block turns a two-byte command (address and instruction) into a continuous DCC track signal on a complementary pair of lines. Each bit is a high phase followed by a low phase. The high and low tick counts for a one and for a zero are set independently, so both the bit period and the duty cycle can be varied. The block appends a checksum byte, frames each byte with a zero start bit and ends the packet with a one bit. The preamble is fourteen ones plus a programmable number of extra ones. When no command is waiting, idle packets (address 0xFF, instruction 0x00) are sent back to back, so the line never goes quiet.

For conformance testing, three faults can be injected into a loaded packet:
- The first zero after the preamble can be given its own, longer timing.
- Any single bit position can be inverted.
- The packet can be cut short by a chosen number of bits. The next packet then starts at once.

Commands are offered on a valid/ready handshake that is only open at packet boundaries. Fault settings and the extra preamble count are captured when a packet is accepted. Timing values are read whenever a bit starts.

Top module: `dcc_fault_gen`

## Requirements
- R1: `track_b` is always the inverse of `track_a`.
- R2: Bit index 0 is the first sent bit. Bits go out in this order:
  - P = 14 + `extra_pre` ones;
  - a 0 at index P;
  - the address, MSB first;
  - a 0;
  - the instruction, MSB first;
  - a 0;
  - the checksum (address XOR instruction), MSB first;
  - a final 1.
  A packet therefore has P + 28 bits.
- R3: A 1 bit holds `track_a` high for `one_hi` ticks and then low for `one_lo` ticks. A 0 bit does the same with `zero_hi` and `zero_lo`. Each new packet's first bit starts on the tick after the previous packet's last tick.
- R4: A timing value of zero is treated as one tick.
- R5: With `stretch_en` captured at accept, the bit at index P takes a stretched timing when its value is 0:
  - high for `stretch_hi` ticks (with a zero value treated as one tick);
  - low for `stretch_total` minus that high time, or for one tick if `stretch_total` is not larger.
  Every other 0 bit keeps the normal timing.
- R6: With `flip_en` captured at accept, the bit at index `flip_pos` is inverted. It takes the timing of its inverted value. A position at or beyond the packet length has no effect.
- R7: A loaded packet sends its length minus `trunc_cnt` bits, and always at least one bit.
- R8: When no packet is accepted at a boundary, an idle packet is sent. Idle packets never carry faults. The checksum of an idle packet is 0xFF.
- R9: `pkt_ready` is high only during the last tick of a packet, and also in the first cycle after reset. The packet is taken when `pkt_valid` and `pkt_ready` are both high at a clock edge.
- R10: `pkt_done` is high during the last tick of a loaded packet, and never at the end of an idle packet.
- R11: After reset, `track_a` is low and `track_b` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | A command is offered |
| pkt_ready | output | 1 | Packet boundary; the offered command is taken |
| pkt_addr | input | 8 | Address byte |
| pkt_cmd | input | 8 | Instruction byte |
| one_hi | input | 16 | High ticks of a 1 bit |
| one_lo | input | 16 | Low ticks of a 1 bit |
| zero_hi | input | 16 | High ticks of a 0 bit |
| zero_lo | input | 16 | Low ticks of a 0 bit |
| extra_pre | input | 4 | Extra preamble ones |
| stretch_en | input | 1 | Stretch the first zero after the preamble |
| stretch_total | input | 16 | Stretched zero total ticks |
| stretch_hi | input | 16 | Stretched zero high ticks |
| flip_en | input | 1 | Invert one bit |
| flip_pos | input | 8 | Index of the inverted bit |
| trunc_cnt | input | 8 | Bits removed from the packet end |
| track_a | output | 1 | Track signal, true line |
| track_b | output | 1 | Track signal, complement line |
| pkt_done | output | 1 | Last tick of a loaded packet |

## Verification
The assertions assume that `pkt_valid` is only evaluated at boundaries, and that timing inputs do not matter between bit starts. Beyond that, they rely on nothing from the stimulus. Every edge and every handshake relation is checked against the bit-end event the design brings out.

The bench holds the timing and fault inputs steady from before a command is offered until that packet has ended. This keeps each measured bit tied to one known setting. Random settings include zero timings, flip positions past the packet end, and truncation counts larger than the packet.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int TICK_W    = 16;
  localparam int IDX_W     = 8;
  localparam int EXTRA_W   = 4;
  localparam int BASE_PRE  = 14;
  localparam int BODY_BITS = 28;   // three framed bytes plus the end bit
  localparam logic [7:0] IDLE_ADDR = 8'hFF;
  localparam logic [7:0] IDLE_CMD  = 8'h00;

  // zero durations become a single tick
  function automatic logic [TICK_W-1:0] min_one(input logic [TICK_W-1:0] t);
    return (t == '0) ? TICK_W'(1) : t;
  endfunction

  function automatic logic [TICK_W-1:0] stretch_low(input logic [TICK_W-1:0] total,
                                                    input logic [TICK_W-1:0] hi);
    logic [TICK_W-1:0] h;
    h = min_one(hi);
    return (total > h) ? total - h : TICK_W'(1);
  endfunction

  // nominal value of bit idx in a packet whose preamble is pre bits long
  function automatic logic pkt_bit(input logic [IDX_W-1:0] idx, input logic [IDX_W-1:0] pre,
                                   input logic [7:0] addr, input logic [7:0] cmd);
    logic [IDX_W-1:0] r;
    logic [IDX_W-1:0] off;
    logic [7:0] byt;
    if (idx < pre) return 1'b1;
    r = idx - pre;
    if (r == 0 || r == 9 || r == 18) return 1'b0;
    if (r >= 27) return 1'b1;
    if (r < 9) begin
      byt = addr;       off = r - IDX_W'(1);
    end else if (r < 18) begin
      byt = cmd;        off = r - IDX_W'(10);
    end else begin
      byt = addr ^ cmd; off = r - IDX_W'(19);
    end
    return byt[3'(IDX_W'(7) - off)];
  endfunction

  function automatic logic [IDX_W-1:0] send_len(input logic [IDX_W-1:0] total,
                                                input logic [IDX_W-1:0] trunc);
    return (trunc < total) ? total - trunc : IDX_W'(1);
  endfunction
endpackage

// File: rtl/dcc_bit_timer.sv
module dcc_bit_timer #(
  parameter int TW = dcc_pkg::TICK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_hi,
  input  logic [TW-1:0] load_lo,
  output logic          level,
  output logic          bit_end
);
  logic          phase_hi;
  logic [TW-1:0] cnt;
  logic [TW-1:0] lo_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_hi <= 1'b0;
      cnt      <= '0;
      lo_hold  <= TW'(1);
    end else if (load) begin
      phase_hi <= 1'b1;
      cnt      <= load_hi - TW'(1);
      lo_hold  <= load_lo;
    end else if (cnt != '0) begin
      cnt <= cnt - TW'(1);
    end else if (phase_hi) begin
      phase_hi <= 1'b0;
      cnt      <= lo_hold - TW'(1);
    end
  end

  assign level   = phase_hi;
  assign bit_end = !phase_hi && (cnt == '0);
endmodule

// File: rtl/dcc_pkt_seq.sv
module dcc_pkt_seq
  import dcc_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int EW = EXTRA_W,
  parameter int TW = TICK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_end,
  input  logic          pkt_valid,
  input  logic [7:0]    pkt_addr,
  input  logic [7:0]    pkt_cmd,
  input  logic [EW-1:0] extra_pre,
  input  logic          flip_en,
  input  logic [IW-1:0] flip_pos,
  input  logic [IW-1:0] trunc_cnt,
  input  logic          stretch_en,
  input  logic [TW-1:0] one_hi,
  input  logic [TW-1:0] one_lo,
  input  logic [TW-1:0] zero_hi,
  input  logic [TW-1:0] zero_lo,
  input  logic [TW-1:0] stretch_total,
  input  logic [TW-1:0] stretch_hi,
  output logic          boundary,
  output logic          cur_user,
  output logic          load,
  output logic [TW-1:0] load_hi,
  output logic [TW-1:0] load_lo
);
  logic [IW-1:0] idx, pre, len, fpos;
  logic [7:0]    addr, cmd;
  logic          user, fen, sen;

  logic [IW-1:0] n_idx, n_pre, n_len, n_fpos, n_total;
  logic [7:0]    n_addr, n_cmd;
  logic          n_user, n_fen, n_sen;
  logic          bitv, stretched;

  assign boundary = bit_end && (idx == len - IW'(1));
  assign cur_user = user;
  assign load     = bit_end;

  always_comb begin
    n_total = IW'(BASE_PRE) + IW'(extra_pre) + IW'(BODY_BITS);
    if (boundary) begin
      n_user = pkt_valid;
      n_addr = pkt_valid ? pkt_addr : IDLE_ADDR;
      n_cmd  = pkt_valid ? pkt_cmd  : IDLE_CMD;
      n_pre  = IW'(BASE_PRE) + IW'(extra_pre);
      n_idx  = '0;
      n_fen  = pkt_valid && flip_en;
      n_fpos = flip_pos;
      n_sen  = pkt_valid && stretch_en;
      n_len  = pkt_valid ? send_len(n_total, trunc_cnt) : n_total;
    end else begin
      n_user = user;  n_addr = addr;  n_cmd = cmd;  n_pre = pre;
      n_idx  = idx + IW'(1);
      n_fen  = fen;   n_fpos = fpos;  n_sen = sen;  n_len = len;
    end
    bitv      = pkt_bit(n_idx, n_pre, n_addr, n_cmd) ^ (n_fen && (n_idx == n_fpos));
    stretched = n_sen && (n_idx == n_pre) && !bitv;
    if (stretched) begin
      load_hi = min_one(stretch_hi);
      load_lo = stretch_low(stretch_total, stretch_hi);
    end else if (bitv) begin
      load_hi = min_one(one_hi);
      load_lo = min_one(one_lo);
    end else begin
      load_hi = min_one(zero_hi);
      load_lo = min_one(zero_lo);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;      pre <= '0;  len <= IW'(1);  fpos <= '0;
      addr <= '0;      cmd <= '0;
      user <= 1'b0;    fen <= 1'b0; sen <= 1'b0;
    end else if (bit_end) begin
      idx  <= n_idx;   pre <= n_pre; len <= n_len; fpos <= n_fpos;
      addr <= n_addr;  cmd <= n_cmd;
      user <= n_user;  fen <= n_fen; sen <= n_sen;
    end
  end
endmodule

// File: rtl/dcc_fault_gen.sv
module dcc_fault_gen
  import dcc_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int EW = EXTRA_W,
  parameter int TW = TICK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pkt_valid,
  output logic          pkt_ready,
  input  logic [7:0]    pkt_addr,
  input  logic [7:0]    pkt_cmd,
  input  logic [TW-1:0] one_hi,
  input  logic [TW-1:0] one_lo,
  input  logic [TW-1:0] zero_hi,
  input  logic [TW-1:0] zero_lo,
  input  logic [EW-1:0] extra_pre,
  input  logic          stretch_en,
  input  logic [TW-1:0] stretch_total,
  input  logic [TW-1:0] stretch_hi,
  input  logic          flip_en,
  input  logic [IW-1:0] flip_pos,
  input  logic [IW-1:0] trunc_cnt,
  output logic          track_a,
  output logic          track_b,
  output logic          pkt_done
);
  // internal events named for the checker
  logic          bit_end;
  logic          boundary;
  logic          cur_user;
  logic          load;
  logic [TW-1:0] load_hi, load_lo;
  logic          level;

  dcc_pkt_seq #(.IW(IW), .EW(EW), .TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n), .bit_end(bit_end),
    .pkt_valid(pkt_valid), .pkt_addr(pkt_addr), .pkt_cmd(pkt_cmd),
    .extra_pre(extra_pre), .flip_en(flip_en), .flip_pos(flip_pos),
    .trunc_cnt(trunc_cnt), .stretch_en(stretch_en),
    .one_hi(one_hi), .one_lo(one_lo), .zero_hi(zero_hi), .zero_lo(zero_lo),
    .stretch_total(stretch_total), .stretch_hi(stretch_hi),
    .boundary(boundary), .cur_user(cur_user), .load(load),
    .load_hi(load_hi), .load_lo(load_lo)
  );

  dcc_bit_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load),
    .load_hi(load_hi), .load_lo(load_lo),
    .level(level), .bit_end(bit_end)
  );

  assign track_a   = level;
  assign track_b   = ~level;
  assign pkt_ready = boundary;
  assign pkt_done  = boundary && cur_user;
endmodule

// File: rtl/dcc_fault_gen_chk.sv
module dcc_fault_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic track_a,
  input logic track_b,
  input logic pkt_ready,
  input logic pkt_done,
  input logic bit_end,
  input logic cur_user
);
  p_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
    track_b == !track_a);

  p_ready_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |-> bit_end);

  p_done_with_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> pkt_ready);

  p_idle_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> cur_user);

  p_rise_after_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(track_a) |-> $past(bit_end));

  p_end_in_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> !track_a);

  p_fall_not_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(track_a) |-> !$past(bit_end));
endmodule

bind dcc_fault_gen dcc_fault_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .track_a(track_a), .track_b(track_b),
  .pkt_ready(pkt_ready), .pkt_done(pkt_done),
  .bit_end(bit_end), .cur_user(cur_user)
);

// File: tb/tb_dcc_fault_gen.sv
module tb_dcc_fault_gen;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0;
  logic        pkt_ready, pkt_done, track_a, track_b;
  logic [7:0]  pkt_addr = '0, pkt_cmd = '0;
  logic [15:0] one_hi = 16'd3, one_lo = 16'd3, zero_hi = 16'd5, zero_lo = 16'd4;
  logic [3:0]  extra_pre = '0;
  logic        stretch_en = 1'b0, flip_en = 1'b0;
  logic [15:0] stretch_total = 16'd20, stretch_hi = 16'd12;
  logic [7:0]  flip_pos = '0, trunc_cnt = '0;

  dcc_fault_gen dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_addr(pkt_addr), .pkt_cmd(pkt_cmd),
    .one_hi(one_hi), .one_lo(one_lo), .zero_hi(zero_hi), .zero_lo(zero_lo),
    .extra_pre(extra_pre), .stretch_en(stretch_en),
    .stretch_total(stretch_total), .stretch_hi(stretch_hi),
    .flip_en(flip_en), .flip_pos(flip_pos), .trunc_cnt(trunc_cnt),
    .track_a(track_a), .track_b(track_b), .pkt_done(pkt_done)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // line monitor: measured high/low runs of each bit
  int hist_h[0:1023], hist_l[0:1023];
  int wp = 0, run_h = 0, run_l = 0;
  bit mon_on = 0;

  function automatic void push_bit();
    hist_h[wp & 1023] = run_h;
    hist_l[wp & 1023] = run_l;
    wp++;
    run_h = 0;
    run_l = 0;
  endfunction

  always @(negedge clk) if (mon_on) begin
    checks++;
    if (track_b !== ~track_a) begin
      fails++;
      $display("FAIL R1 pair: a=%b b=%b expected b=%b", track_a, track_b, ~track_a);
    end
    if (track_a) begin
      if (run_l > 0) push_bit();
      run_h++;
    end else run_l++;
    if (pkt_ready && run_h > 0) push_bit();
  end

  // expected bit list, built from the requirements
  int ev[0:63], eh[0:63], el[0:63];
  int en;

  function automatic int tick(int t);
    if (t == 0) return 1;
    return t;
  endfunction

  function automatic void build(int a, int c, int extra, bit fe, int fp, int tr, bit se);
    int p, k, tot;
    int bytes[3];
    p = 14 + extra;
    k = 0;
    bytes[0] = a; bytes[1] = c; bytes[2] = a ^ c;
    for (int i = 0; i < p; i++) begin ev[k] = 1; k++; end
    for (int j = 0; j < 3; j++) begin
      ev[k] = 0; k++;
      for (int b = 7; b >= 0; b--) begin ev[k] = (bytes[j] >> b) & 1; k++; end
    end
    ev[k] = 1; k++;
    tot = k;
    if (fe && fp < tot) ev[fp] = 1 - ev[fp];
    en = (tr < tot) ? tot - tr : 1;
    for (int i = 0; i < en; i++) begin
      if (se && i == p && ev[i] == 0) begin
        eh[i] = tick(int'(stretch_hi));
        el[i] = (int'(stretch_total) > eh[i]) ? int'(stretch_total) - eh[i] : 1;
      end else if (ev[i] == 1) begin
        eh[i] = tick(int'(one_hi));  el[i] = tick(int'(one_lo));
      end else begin
        eh[i] = tick(int'(zero_hi)); el[i] = tick(int'(zero_lo));
      end
    end
  endfunction

  task automatic wait_ready();
    do begin @(negedge clk); #1; end while (!pkt_ready);
  endtask

  task automatic compare(string rq, int start, int stop, bit want_done);
    checks++;
    if (stop - start != en) begin
      fails++;
      $display("FAIL %s bit count: actual %0d expected %0d", rq, stop - start, en);
    end else begin
      for (int i = 0; i < en; i++) begin
        checks++;
        if (hist_h[(start + i) & 1023] != eh[i] || hist_l[(start + i) & 1023] != el[i]) begin
          fails++;
          $display("FAIL %s bit %0d: actual hi/lo %0d/%0d expected %0d/%0d", rq, i,
                   hist_h[(start + i) & 1023], hist_l[(start + i) & 1023], eh[i], el[i]);
        end
      end
    end
    checks++;
    if (pkt_done !== want_done) begin
      fails++;
      $display("FAIL R10 done at packet end: actual %b expected %b", pkt_done, want_done);
    end
  endtask

  // offer a command, then measure the whole packet
  task automatic run_pkt(string rq, int a, int c);
    int s;
    pkt_addr = 8'(a);
    pkt_cmd = 8'(c);
    pkt_valid = 1'b1;
    wait_ready();
    s = wp;
    @(posedge clk); #1;
    pkt_valid = 1'b0;
    build(a, c, int'(extra_pre), flip_en, int'(flip_pos), int'(trunc_cnt), stretch_en);
    wait_ready();
    compare(rq, s, wp, 1'b1);
  endtask

  // the packet right after a command is idle and clean (R8)
  task automatic run_idle();
    int s;
    s = wp;
    build(8'hFF, 8'h00, int'(extra_pre), 1'b0, 0, 0, 1'b0);
    wait_ready();
    compare("R8 idle", s, wp, 1'b0);
  endtask

  task automatic clear_faults();
    stretch_en = 0; flip_en = 0; trunc_cnt = 0; extra_pre = 0;
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state, R9 ready right after reset
    checks++;
    if (track_a !== 1'b0 || track_b !== 1'b1) begin
      fails++;
      $display("FAIL R11 reset lines: actual %b%b expected 01", track_a, track_b);
    end
    checks++;
    if (pkt_ready !== 1'b1) begin
      fails++;
      $display("FAIL R9 ready after reset: actual %b expected 1", pkt_ready);
    end
    mon_on = 1;

    // R2 R3 nominal packet and the idle behind it
    run_pkt("R2 R3 nominal", 8'h03, 8'h46);
    run_idle();
    // R2 extra preamble
    extra_pre = 4'd7;
    run_pkt("R2 extra preamble", 8'hA5, 8'h5A);
    extra_pre = 4'd15;
    run_pkt("R2 max preamble", 8'h80, 8'h01);
    clear_faults();
    // R4 zero timings clamp
    one_hi = 0; one_lo = 0; zero_hi = 0; zero_lo = 2;
    run_pkt("R4 clamp", 8'h3C, 8'hC3);
    one_hi = 3; one_lo = 3; zero_hi = 5; zero_lo = 4;
    // R5 stretch, normal and clamped low
    stretch_en = 1; stretch_total = 30; stretch_hi = 22;
    run_pkt("R5 stretch", 8'h11, 8'h22);
    stretch_total = 6; stretch_hi = 9;
    run_pkt("R5 stretch clamp", 8'h11, 8'h22);
    clear_faults();
    // R6 flips: first, last, start bit, beyond end
    flip_en = 1;
    flip_pos = 0;
    run_pkt("R6 flip first", 8'h55, 8'h0F);
    flip_pos = 8'd41;
    run_pkt("R6 flip last", 8'h55, 8'h0F);
    flip_pos = 8'd14;
    stretch_en = 1; stretch_total = 30; stretch_hi = 22;
    run_pkt("R6 R5 flipped start bit", 8'h55, 8'h0F);
    stretch_en = 0;
    flip_pos = 8'd200;
    run_pkt("R6 flip out of range", 8'h55, 8'h0F);
    clear_faults();
    // R7 truncation, packets back to back
    trunc_cnt = 3;
    run_pkt("R7 truncate 3", 8'h7E, 8'h81);
    trunc_cnt = 8'd255;
    run_pkt("R7 truncate to one bit", 8'h7E, 8'h81);
    run_idle();
    clear_faults();

    // constrained random packets
    for (int n = 0; n < 14; n++) begin
      one_hi = 16'($urandom_range(0, 7));
      one_lo = 16'($urandom_range(1, 7));
      zero_hi = 16'($urandom_range(1, 9));
      zero_lo = 16'($urandom_range(0, 9));
      extra_pre = 4'($urandom_range(0, 15));
      stretch_en = 1'($urandom_range(0, 1));
      stretch_total = 16'($urandom_range(0, 40));
      stretch_hi = 16'($urandom_range(0, 30));
      flip_en = 1'($urandom_range(0, 1));
      flip_pos = 8'($urandom_range(0, 70));
      trunc_cnt = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 80)) : 8'd0;
      run_pkt("R2 R3 R5 R6 R7 random", int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
      if (n % 5 == 0) run_idle();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule